// File: doc/BRIEF.md
# Software Reset Status Controller

This block keeps a small status word that tells system software why the chip last came out of reset. Five cause flags occupy the top of a 32-bit word: power-on, software power-on, software external reset, button power-on and button external reset. The flag group is laid out from bit 31 down to bit 27. Software reads the word through a simple 32-bit register port. It also writes the word to acknowledge causes and to ask for a new system reset. Any such request leaves the block as a single-cycle pulse.

A saturating counter of reset events tells the first reset after power-up apart from later warm resets. The first reset loads the word with only the power-on flag. Warm resets leave the word as software last left it. A software power-on command zeroes the counter, so the reset that follows is again reported as power-on. The `rst` input is the system reset itself, seen by this block as the event it records. Nothing in this block sets the two button flags. They are kept so that the layout of the word matches what software decodes.

Top module: `rst_status_ctrl`

## Requirements
- R1: The first cycle of `rst` after power-up, while the event counter is zero, loads the status word with 0x80000000: bit 31 set and every other bit clear.
- R2: A write to the data word clears each of bits 31, 28 and 27 whose written bit is 1. It leaves those bits unchanged where the written bit is 0. Bits 28 and 27 read 0, because nothing in the block sets them.
- R3: A write to the data word loads bits 30 and 29 with the written values, so a written 0 clears them.
- R4: A write with bit 30 set drives `rst_req` high in the cycle after the write. It zeroes the event counter, so the next `rst` loads 0x80000000 again.
- R5: A write with bit 29 set and bit 30 clear drives `rst_req` high in the cycle after the write. The counter is left as it is, so the next `rst` leaves the status word unchanged.
- R6: `rst_req` is high only in the cycle right after a data-word write that has bit 30 or bit 29 set. It is low after a single such write has gone by and while `rst` is high.
- R7: Any `rst` seen while the counter is nonzero leaves the status word unchanged. The counter saturates at 2^CNT_W-1, so no number of resets brings back the power-on load without a software power-on command.
- R8: The data word sits at byte address OFFSET+4 and the word at OFFSET reads 0. Address bits 1:0 are ignored. Bits 26:0 of the data word read 0. Any other address reads 0, and a write to it changes neither the status nor `rst_req`.
- R9: `rdata` is loaded in the cycle after `rd_en` is sampled high, and it holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset event, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (16) | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Corrupted cause flags show on the very next read of the data word. The event counter is the dangerous part, because its state is hidden. A counter that is off by one, wraps, or is not zeroed by a software power-on command shows up only after the next `rst`. It appears as a status word that holds 0x80000000 when it should be unchanged, or the reverse. The bench therefore reads the word after every reset, across saturation, and after both command kinds. `rst_req` errors show at the ports one cycle after the write.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int DATA_W   = 32;
  localparam int NCAUSE   = 5;
  localparam int CAUSE_LO = DATA_W - NCAUSE;

  // field order is the bit order 31..27 that software decodes
  typedef struct packed {
    logic pwr_on;     // 31 power-on
    logic sw_pwr_on;  // 30 software power-on command
    logic sw_ext;     // 29 software external reset command
    logic btn_pwr_on; // 28 button power-on
    logic btn_ext;    // 27 button external reset
  } cause_t;

  localparam cause_t CAUSE_POR_ONLY = '{pwr_on: 1'b1, default: 1'b0};
endpackage

// File: rtl/rsc_addr_dec.sv
module rsc_addr_dec #(
  parameter int AW = 16,
  parameter logic [AW-1:0] OFFSET = 16'hF020
) (
  input  logic [AW-1:0] addr,
  output logic          hit_data
);
  localparam logic [AW-1:0] DATA_ADDR = OFFSET + AW'(4);

  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  assign hit_data = (addr[AW-1:2] == DATA_ADDR[AW-1:2]);
endmodule

// File: rtl/rsc_boot_count.sv
module rsc_boot_count #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic first
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // power-up value: the counter is not cleared by the event it counts
  logic [CNT_W-1:0] cnt_q = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clr) begin
      cnt_q <= '0;
    end
  end

  assign first = (cnt_q == '0);

  // R7: saturation, never wraps to zero by counting
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

  // R4: a software power-on command re-arms power-on detection
  a_r4_rearm: assert property (@(posedge clk) disable iff (rst)
    clr |=> first);
endmodule

// File: rtl/rsc_cause_reg.sv
module rsc_cause_reg
  import rsc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   first,
  input  logic   wr,
  input  cause_t wcause,
  output cause_t cause_q
);
  cause_t cause_r = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (first) cause_r <= CAUSE_POR_ONLY;
    end else if (wr) begin
      cause_r.pwr_on     <= cause_r.pwr_on     & ~wcause.pwr_on;
      cause_r.btn_pwr_on <= cause_r.btn_pwr_on & ~wcause.btn_pwr_on;
      cause_r.btn_ext    <= cause_r.btn_ext    & ~wcause.btn_ext;
      cause_r.sw_pwr_on  <= wcause.sw_pwr_on;
      cause_r.sw_ext     <= wcause.sw_ext;
    end
  end

  assign cause_q = cause_r;

  // R1: first reset reports power-on only
  a_r1_por_load: assert property (@(posedge clk) disable iff (rst)
    $past(rst && first) |-> (cause_q == CAUSE_POR_ONLY));

  // R7: a warm reset leaves the word untouched
  a_r7_warm_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(first)) |-> (cause_q == $past(cause_q)));

  // R2: written ones clear the sticky flags
  a_r2_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr && wcause.pwr_on) |=> !cause_q.pwr_on);

  // R3: command bits follow the written value
  a_r3_direct: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cause_q.sw_pwr_on == $past(wcause.sw_pwr_on)) &&
           (cause_q.sw_ext == $past(wcause.sw_ext)));
endmodule

// File: rtl/rsc_req_pulse.sv
module rsc_req_pulse
  import rsc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr,
  input  cause_t wcause,
  output logic   req
);
  logic req_q = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= wr & (wcause.sw_pwr_on | wcause.sw_ext);
  end

  assign req = req_q;

  // R6: a request only ever follows a command write
  a_r6_req_cause: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(wr && (wcause.sw_pwr_on || wcause.sw_ext)));

  // R6: a single command write gives exactly one cycle of request
  a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
    (req && !$past(wr, 1)) |-> 1'b0 ) ;
endmodule

// File: rtl/rst_status_ctrl.sv
module rst_status_ctrl
  import rsc_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] OFFSET = 16'hF020,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req
);
  logic   hit_data;
  logic   wr_hit;
  logic   first;
  cause_t wcause;
  cause_t cause_q;
  logic   unused_wlow;

  assign wcause      = cause_t'(wdata[DATA_W-1:CAUSE_LO]);
  assign unused_wlow = ^wdata[CAUSE_LO-1:0];

  rsc_addr_dec #(.AW(AW), .OFFSET(OFFSET)) u_dec (
    .addr     (addr),
    .hit_data (hit_data)
  );

  assign wr_hit = wr_en & hit_data;

  rsc_boot_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (wr_hit & wcause.sw_pwr_on),
    .first (first)
  );

  rsc_cause_reg u_cause (
    .clk     (clk),
    .rst     (rst),
    .first   (first),
    .wr      (wr_hit),
    .wcause  (wcause),
    .cause_q (cause_q)
  );

  rsc_req_pulse u_req (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_hit),
    .wcause (wcause),
    .req    (rst_req)
  );

  logic [DATA_W-1:0] rdata_q = '0;

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= hit_data ? {cause_q, {CAUSE_LO{1'b0}}} : '0;
  end

  assign rdata = rdata_q;

  // R8: reads away from the data word return zero
  a_r8_zero_word: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit_data) |=> (rdata == '0));

  // R8: low bits of the data word are always zero
  a_r8_low_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rdata[CAUSE_LO-1:0] == '0));

  // R9: read data holds without a read strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_rst_status_ctrl.sv
module test_rst_status_ctrl;
  localparam int CLK_P = 10;
  localparam int CNT_MAX = 15;
  localparam logic [15:0] A_DATA = 16'hF024;
  localparam logic [15:0] A_ZERO = 16'hF020;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_stat = '0;
  int          m_cnt = 0;
  logic [31:0] m_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  rst_status_ctrl i_rst_status_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  function automatic bit is_data(logic [15:0] a);
    return a[15:2] == A_DATA[15:2];
  endfunction

  function automatic logic [31:0] exp_read(logic [15:0] a);
    return is_data(a) ? m_stat : 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    if (m_cnt == 0) m_stat = 32'h8000_0000;
    if (m_cnt < CNT_MAX) m_cnt++;
    m_rdata = 32'h0;
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_reset();
    end
    rst = 1'b0;
  endtask

  task automatic do_write(logic [15:0] a, logic [31:0] d, string tag);
    logic exp_req;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    exp_req = 1'b0;
    if (is_data(a)) begin
      m_stat = ((m_stat & ~(d & 32'h9800_0000)) & 32'h9800_0000)
             | (d & 32'h6000_0000);
      if (d[30]) m_cnt = 0;
      exp_req = d[30] | d[29];
    end
    check(tag, {31'b0, rst_req}, {31'b0, exp_req});
  endtask

  task automatic do_read(logic [15:0] a, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    m_rdata = exp_read(a);
    check(tag, rdata, m_rdata);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      model_reset();
    end
    rst = 1'b0;

    // reset state
    do_read(A_DATA, "R1 power-on load");
    check("R6 no request after reset", {31'b0, rst_req}, 32'h0);
    do_read(A_ZERO, "R8 zero word");
    do_read(16'hF028, "R8 other address");
    do_read(16'hF027, "R8 low address bits ignored");

    // write-one-to-clear
    do_write(A_DATA, 32'h0000_0000, "R2 zero write no request");
    do_read(A_DATA, "R2 zero leaves bit 31");
    do_write(A_DATA, 32'h8000_0000, "R2 clear write no request");
    do_read(A_DATA, "R2 bit 31 cleared");
    do_write(A_DATA, 32'h1800_0000, "R2 button bits");
    do_read(A_DATA, "R2 button bits read zero");

    // software external reset
    do_write(A_DATA, 32'h2000_0000, "R5 request pulse");
    @(negedge clk);
    check("R6 pulse one cycle", {31'b0, rst_req}, 32'h0);
    do_read(A_DATA, "R3 bit 29 written");
    do_reset(1);
    do_read(A_DATA, "R5 warm reset keeps word");
    do_write(A_DATA, 32'h0000_0000, "R3 clear command bits");
    do_read(A_DATA, "R3 bit 29 cleared by zero");

    // writes elsewhere ignored
    do_write(A_ZERO, 32'h4000_0000, "R8 write elsewhere no request");
    do_read(A_DATA, "R8 write elsewhere no effect");

    // software power-on
    do_write(A_DATA, 32'h4000_0000, "R4 request pulse");
    do_read(A_DATA, "R3 bit 30 written");
    do_reset(2);
    do_read(A_DATA, "R4 power-on after command");

    // saturation
    do_write(A_DATA, 32'h8000_0000, "R2 clear before saturation");
    for (int i = 0; i < 20; i++) do_reset(1);
    do_read(A_DATA, "R7 saturated counter keeps word");
    do_write(A_DATA, 32'h4000_0000, "R4 request after saturation");
    do_reset(1);
    do_read(A_DATA, "R4 power-on after saturation");

    // read hold
    do_write(A_DATA, 32'h8000_0000, "R9 change state");
    @(negedge clk);
    check("R9 rdata holds", rdata, m_rdata);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [15:0] a;
      logic [31:0] d;
      case ($urandom_range(0, 3))
        0: a = {A_DATA[15:2], 2'($urandom_range(0, 3))};
        1: a = A_ZERO;
        2: a = 16'hF028;
        default: a = 16'($urandom);
      endcase
      d = $urandom;
      op = $urandom_range(0, 9);
      if (op < 5)       do_write(a, d, "R3 random write");
      else if (op < 9)  do_read(a, "R8 random read");
      else              do_reset($urandom_range(1, 3));
      if (op < 5 && (it % 8) == 0) begin
        @(negedge clk);
        check("R9 random hold", rdata, m_rdata);
      end
    end
    do_read(A_DATA, "R7 final word");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule